// File: doc/BRIEF.md
# Channel Status Word Sequencer

This block feeds the channel-status slot of a serial digital-audio transmitter. Software fills six 32-bit words, named A to F, which together hold a 192-bit status block. The frame generator sends a strobe at every frame boundary. It raises a second strobe on the boundary that opens a new 192-frame block. The sequencer then gives out one status bit per frame. Words are taken in order A, B, C, D, E, F, and each word is sent from its least significant bit up.

Each word is copied into an internal shifter only at the moment it is needed. A host write therefore reaches the line the next time that word is loaded. The busy flag follows these loads: it rises when word A enters the shifter and falls when word F enters it. Removing transmit-enable does not cut the output mid-frame. The current bit is held until the next frame boundary, and the block ends there. Line coding, preambles and audio data are handled elsewhere.

Top module: `cs_word_sequencer`

## Requirements
- R1: After reset, `csBit` and `csBusy` are both 0.
- R2: A write with `wrEn` high and `wrAddr` 0 to 5 stores `wrData` into word A to F (0=A, 5=F). Writes to addresses 6 and 7 change no word.
- R3: A frame strobe that carries `blockStart` while `txEnable` and `csEnable` are both 1 loads word A. After that edge `csBusy` is 1 and `csBit` equals bit 0 of word A.
- R4: Each later frame strobe advances one bit. Frame n of the block (n = 0..191) shows bit n mod 32 of word n div 32, with word index 0 = A.
- R5: `csBusy` falls on the frame strobe that loads word F (frame 160) and stays 0 for the rest of the block.
- R6: After frame 191, the next frame strobe ends the block. `csBit` is then 0 until a new block start.
- R7: While `csEnable` is 0 during a block, `csBit` is 0 but the bit position keeps advancing. When `csEnable` returns, the output resumes at the bit for the current frame.
- R8: If `txEnable` drops during a block, the current bit and busy hold until the next frame strobe. At that strobe both go to 0.
- R9: A block start with either enable low starts no block. `csBusy` and `csBit` stay 0.
- R10: A word written during a block takes effect when that word is next loaded. A write to the word already in the shifter leaves the bits of that word still to be sent unchanged.
- R11: Without a frame strobe, `csBit` and `csBusy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Word select, 0=A .. 5=F |
| wrData | input | 32 | Write data |
| txEnable | input | 1 | Transmit enable |
| csEnable | input | 1 | Channel-status enable |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| blockStart | input | 1 | Marks the frame strobe that opens a block; read only together with frameStrobe |
| csBit | output | 1 | Channel-status bit for the current frame |
| csBusy | output | 1 | High from the load of word A until the load of word F |

## Verification
A host write and a word load can land on the same block position. The write can target the word just loaded, whose remaining bits must not change. It can also target a word not yet loaded, which must show the new value. The bench provokes this by rewriting words A and C while word A is being sent. It then judges every later frame against a model that copies each word at its own load frame. A second overlap is the removal of transmit-enable against the pending frame strobe. The bench checks that the bit and busy hold before that strobe and both clear after it.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;    // copy the selected word into the shifter
    logic shift;   // move to the next bit of the current word
    logic active;  // a block is being sent
  } seqStrb_t;
endpackage

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int CNT_W    = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txEnable,
  input  logic             csEnable,
  input  logic             frameStrobe,
  input  logic             blockStart,
  output seqStrb_t         strb,
  output logic [IDX_W-1:0] wordSel,
  output logic             csBusy
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_W - 1);

  logic             running;
  logic             stopNow;
  logic [IDX_W-1:0] wordIdx;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb.load  = 1'b0;
    strb.shift = 1'b0;
    strb.active = running;
    stopNow    = 1'b0;
    wordSel    = '0;
    if (frameStrobe) begin
      if (blockStart && txEnable && csEnable) begin
        strb.load = 1'b1;
      end else if (running && !txEnable) begin
        stopNow = 1'b1;
      end else if (running) begin
        if (bitCnt == LAST_BIT) begin
          if (wordIdx == LAST_WORD) begin
            stopNow = 1'b1;
          end else begin
            strb.load = 1'b1;
            wordSel   = wordIdx + 1'b1;
          end
        end else begin
          strb.shift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      csBusy  <= 1'b0;
      wordIdx <= '0;
      bitCnt  <= '0;
    end else if (strb.load) begin
      running <= 1'b1;
      csBusy  <= (wordSel != LAST_WORD);
      wordIdx <= wordSel;
      bitCnt  <= '0;
    end else if (strb.shift) begin
      bitCnt  <= bitCnt + 1'b1;
    end else if (stopNow) begin
      running <= 1'b0;
      csBusy  <= 1'b0;
    end
  end

  // R3: busy only rises on a block-start frame
  a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csBusy) |-> $past(frameStrobe && blockStart));
  // R5, R8: busy only falls at a frame boundary
  a_r5_busy_fall_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csBusy) |-> $past(frameStrobe));
  a_r8_busy_needs_block: assert property (@(posedge clk) disable iff (!rst_n)
    csBusy |-> running);
  a_r4_word_range: assert property (@(posedge clk) disable iff (!rst_n)
    wordIdx <= LAST_WORD);
  a_r11_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStrobe |=> $stable(bitCnt) && $stable(wordIdx));
endmodule

// File: rtl/cs_seq_datapath.sv
module cs_seq_datapath
  import cs_seq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              csEnable,
  input  seqStrb_t          strb,
  input  logic [IDX_W-1:0]  wordSel,
  output logic              csBit
);
  logic [WORD_W-1:0] wordReg [NUM_WORDS];
  logic [WORD_W-1:0] shiftReg;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wordReg[w] <= '0;
      end else if (wrEn && wrAddr == IDX_W'(w)) begin
        wordReg[w] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= wordReg[wordSel];
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign csBit = strb.active & csEnable & shiftReg[0];

  // R10, R11: the shifter changes only on a load or shift strobe
  a_r11_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load && !strb.shift |=> $stable(shiftReg));
  // R10: a load takes the word as it stood before the edge
  a_r10_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> shiftReg == $past(wordReg[wordSel]));
endmodule

// File: rtl/cs_word_sequencer.sv
module cs_word_sequencer
  import cs_seq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              txEnable,
  input  logic              csEnable,
  input  logic              frameStrobe,
  input  logic              blockStart,
  output logic              csBit,
  output logic              csBusy
);
  seqStrb_t         strb;
  logic [IDX_W-1:0] wordSel;

  cs_seq_ctrl #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .csEnable(csEnable),
    .frameStrobe(frameStrobe), .blockStart(blockStart),
    .strb(strb), .wordSel(wordSel), .csBusy(csBusy)
  );

  cs_seq_datapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .csEnable(csEnable), .strb(strb), .wordSel(wordSel), .csBit(csBit)
  );
endmodule

// File: tb/sim_cs_word_sequencer.sv
module sim_cs_word_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        txEnable = 1'b0;
  logic        csEnable = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        blockStart = 1'b0;
  logic        csBit;
  logic        csBusy;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] model   [6];
  logic [31:0] latched [6];

  always #2.5 clk = ~clk;

  cs_word_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txEnable(txEnable), .csEnable(csEnable), .frameStrobe(frameStrobe),
    .blockStart(blockStart), .csBit(csBit), .csBusy(csBusy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (addr < 3'd6) model[addr] = data;
  endtask

  // Pulse one frame strobe; outputs are sampled one cycle later
  task automatic pulseFrame(input bit bs);
    @(negedge clk);
    frameStrobe = 1'b1; blockStart = bs;
    @(negedge clk);
    frameStrobe = 1'b0; blockStart = 1'b0;
  endtask

  // Frame idx of a running block; expOn gates the expected bit
  task automatic blockFrame(input int idx, input bit expOn);
    logic expBit;
    if (idx % 32 == 0) latched[idx/32] = model[idx/32];
    pulseFrame(idx == 0);
    expBit = expOn ? latched[idx/32][idx%32] : 1'b0;
    chk(csBit == expBit, "R4 bit", {31'd0, csBit}, {31'd0, expBit});
    chk(csBusy == (idx < 160), "R5 busy", {31'd0, csBusy}, {31'd0, idx < 160});
  endtask

  task automatic testReset();
    chk(csBit == 1'b0, "R1 bit", {31'd0, csBit}, 0);
    chk(csBusy == 1'b0, "R1 busy", {31'd0, csBusy}, 0);
  endtask

  task automatic testFullBlock();
    writeWord(3'd0, 32'hA5C3_0F1E);
    writeWord(3'd1, 32'h1234_5678);
    writeWord(3'd2, 32'hDEAD_BEEF);
    writeWord(3'd3, 32'h0F0F_00FF);
    writeWord(3'd4, 32'h8000_0001);
    writeWord(3'd5, 32'h7E81_3CC3);
    writeWord(3'd6, 32'hFFFF_FFFF); // R2: ignored address
    writeWord(3'd7, 32'hFFFF_FFFF); // R2: ignored address
    txEnable = 1'b1; csEnable = 1'b1;
    for (int i = 0; i < 192; i++) begin
      blockFrame(i, 1'b1);
      if (i == 0) chk(csBusy == 1'b1, "R3 busy after start", {31'd0, csBusy}, 1);
    end
    pulseFrame(1'b0); // R6: block ends
    chk(csBit == 1'b0, "R6 bit after end", {31'd0, csBit}, 0);
    chk(csBusy == 1'b0, "R6 busy after end", {31'd0, csBusy}, 0);
    pulseFrame(1'b0);
    chk(csBit == 1'b0, "R6 stays idle", {31'd0, csBit}, 0);
  endtask

  task automatic testCsGate();
    for (int i = 0; i < 60; i++) begin
      csEnable = !(i >= 40 && i < 50);
      if (i >= 40 && i < 50) begin
        if (i % 32 == 0) latched[i/32] = model[i/32];
        pulseFrame(1'b0);
        chk(csBit == 1'b0, "R7 gated bit", {31'd0, csBit}, 0);
        chk(csBusy == 1'b1, "R7 busy held", {31'd0, csBusy}, 1);
      end else begin
        blockFrame(i, 1'b1); // R7: resumes on position at frame 50
      end
    end
  endtask

  task automatic testTxStop();
    logic holdBit;
    holdBit = csBit;
    txEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk(csBit == holdBit, "R8 bit holds before strobe", {31'd0, csBit}, {31'd0, holdBit});
    chk(csBusy == 1'b1, "R8 busy holds before strobe", {31'd0, csBusy}, 1);
    pulseFrame(1'b0);
    chk(csBit == 1'b0, "R8 bit after strobe", {31'd0, csBit}, 0);
    chk(csBusy == 1'b0, "R8 busy after strobe", {31'd0, csBusy}, 0);
    txEnable = 1'b1;
  endtask

  task automatic testNoStart();
    txEnable = 1'b1; csEnable = 1'b0;
    pulseFrame(1'b1);
    chk(csBusy == 1'b0, "R9 cs off", {31'd0, csBusy}, 0);
    csEnable = 1'b1; txEnable = 1'b0;
    pulseFrame(1'b1);
    chk(csBusy == 1'b0, "R9 tx off", {31'd0, csBusy}, 0);
    chk(csBit == 1'b0, "R9 bit", {31'd0, csBit}, 0);
    txEnable = 1'b1;
  endtask

  task automatic testMidWrite();
    writeWord(3'd0, 32'hFFFF_0000);
    for (int i = 0; i < 192; i++) begin
      if (i == 6) begin
        writeWord(3'd0, 32'h0000_FFFF); // R10: word in shifter
        writeWord(3'd2, 32'h5A5A_A5A5); // R10: word not loaded yet
      end
      blockFrame(i, 1'b1);
    end
    pulseFrame(1'b0);
  endtask

  task automatic testHold();
    logic b0;
    pulseFrame(1'b1);
    latched[0] = model[0];
    pulseFrame(1'b0);
    b0 = csBit;
    repeat (10) @(negedge clk);
    chk(csBit == b0, "R11 bit hold", {31'd0, csBit}, {31'd0, b0});
    chk(csBit == latched[0][1], "R11 bit value", {31'd0, csBit}, {31'd0, latched[0][1]});
    chk(csBusy == 1'b1, "R11 busy hold", {31'd0, csBusy}, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 6; w++) begin model[w] = '0; latched[w] = '0; end
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFullBlock();
    testNoStart();
    testCsGate();
    testTxStop();
    testMidWrite();
    testHold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule